// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register File

This block is the interrupt and mailbox register file of one processor core. Other cores post interrupt requests to it. A local 32-bit register port reads and writes it. Pending request bits gather in a status register. An enable register qualifies those bits, and a single level interrupt line goes to the core. Eight 32-bit mailbox words carry data between cores.

Software on the owning core can change status only through two write-only ports. The set port ORs bits into status and the clear port removes them. Remote senders use a separate set-request input that acts like a local set write. The interrupt line changes only on set and clear events. A set raises it when the resulting status has an enabled bit. A clear drops it only when status becomes fully empty while the enable register is nonzero.

All accesses are 32-bit and little-endian. Only the low 8 address bits select a register. Read data is combinational and is valid in the same cycle as a read request.

Top module: `ipi_core_regs`

## Requirements
- R1: After reset, status, enable and all eight mailbox words read as zero, and `irq_o` and `wr_err_o` are low.
- R2: Only address bits [7:0] select a register. An access at 0x124 reaches the same register as 0x24.
- R3: A write to the set port (offset 0x08) ORs the data into status. `irq_o` goes high after that edge if the new status ANDed with enable is nonzero.
- R4: A write to the clear port (offset 0x0C) removes the data's one-bits from status. `irq_o` goes low only if status becomes zero while enable is nonzero; otherwise `irq_o` holds its value.
- R5: Status (offset 0x00) is read-only. A write there leaves status unchanged and raises `wr_err_o` for exactly the next cycle. No other access raises `wr_err_o`.
- R6: Reads of the set and clear ports return zero.
- R7: Mailbox word k sits at offset 0x20 + 4k (k = 0..7). It keeps the last value written there and reads it back.
- R8: A read of an unmapped offset (for example 0x40 or 0x44) returns zero. A write there changes no register and does not change `irq_o`.
- R9: A cycle with `remote_set_valid_i` high acts as a set-port write of `remote_set_data_i`. If the same cycle carries a local clear, the clear is applied first and the remote set after it, both to status and to the interrupt decision.
- R10: The enable register (offset 0x04) is read/write. Writing it alone never changes `irq_o`. The interrupt line changes only after a set or clear event.
- R11: A read returns data in the same cycle the request is presented. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (12) | Byte address; bits [7:0] decoded |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, combinational |
| remote_set_valid_i | input | 1 | Remote set-request strobe |
| remote_set_data_i | input | 32 | Bits to OR into status |
| irq_o | output | 1 | Level interrupt to the core |
| wr_err_o | output | 1 | One-cycle flag: write to read-only status |

## Verification
The assertions check the following on every cycle:
- The interrupt line rises only in the cycle after a set event (local or remote).
- It falls only in the cycle after a local clear.
- It holds steady when neither event occurs.
- The error flag appears exactly one cycle after a write to status.
- Set and clear reads return zero.

Some behaviours only the bench scenarios can show, because they depend on register contents:
- The OR and AND-NOT arithmetic on status.
- A clear that keeps the interrupt high because bits remain or enable is zero.
- The ordering when a remote set coincides with a local clear.
- Address aliasing above bit 7.
- Mailbox storage.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam logic [7:0] OFF_STATUS = 8'h00;
  localparam logic [7:0] OFF_ENABLE = 8'h04;
  localparam logic [7:0] OFF_SET    = 8'h08;
  localparam logic [7:0] OFF_CLEAR  = 8'h0C;
  localparam logic [7:0] OFF_MBOX   = 8'h20;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_SET,
    SEL_CLEAR,
    SEL_MBOX
  } reg_sel_e;
endpackage

// File: rtl/ipi_addr_dec.sv
module ipi_addr_dec
  import ipi_pkg::*;
#(
  parameter int MBOX_WORDS = 8,
  localparam int IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic [7:0]       off_i,
  output reg_sel_e         sel_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [8:0] MBOX_LO = {1'b0, OFF_MBOX};
  localparam logic [8:0] MBOX_HI = 9'(int'(OFF_MBOX) + 4 * MBOX_WORDS);

  logic [7:0] diff;
  logic       in_mbox;
  logic       dec_unused;

  assign diff    = off_i - OFF_MBOX;
  assign in_mbox = ({1'b0, off_i} >= MBOX_LO) && ({1'b0, off_i} < MBOX_HI);
  assign idx_o   = diff[IDX_W+1:2];
  assign dec_unused = ^{diff[7:IDX_W+2], diff[1:0]};

  always_comb begin
    sel_o = SEL_NONE;
    unique case ({off_i[7:2], 2'b00})
      OFF_STATUS: sel_o = SEL_STATUS;
      OFF_ENABLE: sel_o = SEL_ENABLE;
      OFF_SET:    sel_o = SEL_SET;
      OFF_CLEAR:  sel_o = SEL_CLEAR;
      default:    sel_o = in_mbox ? SEL_MBOX : SEL_NONE;
    endcase
  end
endmodule

// File: rtl/ipi_status_ctl.sv
module ipi_status_ctl #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] en_i,
  input  logic              set_evt_i,
  input  logic [DATA_W-1:0] set_val_i,
  input  logic              clr_evt_i,
  input  logic [DATA_W-1:0] clr_val_i,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] status_q, mid, fin;
  logic              irq_q, irq_d;

  // clear first, then set
  always_comb begin
    mid   = clr_evt_i ? (status_q & ~clr_val_i) : status_q;
    fin   = set_evt_i ? (mid | set_val_i) : mid;
    irq_d = irq_q;
    if (clr_evt_i && (mid == '0) && (en_i != '0)) irq_d = 1'b0;
    if (set_evt_i && (fin != '0) && ((fin & en_i) != '0)) irq_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= fin;
      irq_q    <= irq_d;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
  parameter int DATA_W     = 32,
  parameter int MBOX_WORDS = 8,
  localparam int IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] word_q [MBOX_WORDS];

  for (genvar w = 0; w < MBOX_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           word_q[w] <= '0;
      else if (we_i && (idx_i == IDX_W'(w))) word_q[w] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < MBOX_WORDS; w++)
      if (idx_i == IDX_W'(w)) rdata_o = word_q[w];
  end
endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
  import ipi_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int MBOX_WORDS = 8,
  localparam int IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              remote_set_valid_i,
  input  logic [DATA_W-1:0] remote_set_data_i,
  output logic              irq_o,
  output logic              wr_err_o
);
  reg_sel_e          sel;
  logic [IDX_W-1:0]  idx;
  logic              wr, rd;
  logic [DATA_W-1:0] en_q, status, mbox_rdata, set_val;
  logic              set_evt, clr_evt;
  logic              err_q;
  logic              addr_unused;

  assign addr_unused = ^req_addr_i[ADDR_W-1:8];

  ipi_addr_dec #(.MBOX_WORDS(MBOX_WORDS)) u_dec (
    .off_i (req_addr_i[7:0]),
    .sel_o (sel),
    .idx_o (idx)
  );

  assign wr = req_valid_i && req_write_i;
  assign rd = req_valid_i && !req_write_i;

  assign set_evt = (wr && sel == SEL_SET) || remote_set_valid_i;
  assign set_val = ((wr && sel == SEL_SET) ? req_wdata_i : '0)
                 | (remote_set_valid_i ? remote_set_data_i : '0);
  assign clr_evt = wr && sel == SEL_CLEAR;

  ipi_status_ctl #(.DATA_W(DATA_W)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_q),
    .set_evt_i (set_evt),
    .set_val_i (set_val),
    .clr_evt_i (clr_evt),
    .clr_val_i (req_wdata_i),
    .status_o  (status),
    .irq_o     (irq_o)
  );

  ipi_mailbox #(.DATA_W(DATA_W), .MBOX_WORDS(MBOX_WORDS)) u_mbox (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr && sel == SEL_MBOX),
    .idx_i   (idx),
    .wdata_i (req_wdata_i),
    .rdata_o (mbox_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr && sel == SEL_ENABLE) en_q <= req_wdata_i;
      err_q <= wr && sel == SEL_STATUS;
    end
  end

  assign wr_err_o = err_q;

  always_comb begin
    rsp_rdata_o = '0;
    if (rd) begin
      unique case (sel)
        SEL_STATUS: rsp_rdata_o = status;
        SEL_ENABLE: rsp_rdata_o = en_q;
        SEL_MBOX:   rsp_rdata_o = mbox_rdata;
        default:    rsp_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ipi_core_regs_chk.sv
module ipi_core_regs_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              remote_set_valid_i,
  input logic              irq_o,
  input logic              wr_err_o
);
  logic [7:0] off;
  logic       w_stat, w_set, w_clr, r_setclr;
  assign off      = {req_addr_i[7:2], 2'b00};
  assign w_stat   = req_valid_i && req_write_i && off == 8'h00;
  assign w_set    = req_valid_i && req_write_i && off == 8'h08;
  assign w_clr    = req_valid_i && req_write_i && off == 8'h0C;
  assign r_setclr = req_valid_i && !req_write_i && (off == 8'h08 || off == 8'h0C);

  p_err_after_status_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_stat |=> wr_err_o);
  p_err_only_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !w_stat |=> !wr_err_o);
  p_irq_rise_on_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(w_set || remote_set_valid_i));
  p_irq_fall_on_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(w_clr));
  p_irq_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(w_set || w_clr || remote_set_valid_i) |=> $stable(irq_o));
  p_setclr_read_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_setclr |-> rsp_rdata_o == '0);
  p_idle_read_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> rsp_rdata_o == '0);
endmodule

bind ipi_core_regs ipi_core_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .req_valid_i        (req_valid_i),
  .req_write_i        (req_write_i),
  .req_addr_i         (req_addr_i),
  .rsp_rdata_o        (rsp_rdata_o),
  .remote_set_valid_i (remote_set_valid_i),
  .irq_o              (irq_o),
  .wr_err_o           (wr_err_o)
);

// File: tb/test_ipi_core_regs.sv
module test_ipi_core_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [11:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [31:0] rsp_rdata_o;
  logic        remote_set_valid_i = 1'b0;
  logic [31:0] remote_set_data_i = '0;
  logic        irq_o, wr_err_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk_i = ~clk_i;

  ipi_core_regs i_ipi_core_regs (.*);

  typedef struct packed {
    logic        wr;
    logic [7:0]  off;
    logic [31:0] dat;
    logic [31:0] exp;   // read: rdata; write: irq_o in bit 0
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h04, 32'h0000_00F0, 32'h0},          // R10 enable, no irq change
    '{1'b1, 8'h08, 32'h0000_0003, 32'h0},          // R3 set, not enabled
    '{1'b0, 8'h00, 32'h0,         32'h0000_0003},  // R3 status read
    '{1'b1, 8'h08, 32'h0000_0010, 32'h1},          // R3 enabled bit raises
    '{1'b0, 8'h04, 32'h0,         32'h0000_00F0},  // R10 enable read
    '{1'b1, 8'h0C, 32'h0000_0010, 32'h1},          // R4 bits left, irq held
    '{1'b0, 8'h00, 32'h0,         32'h0000_0003},  // R4 status after clear
    '{1'b1, 8'h0C, 32'h0000_0003, 32'h0},          // R4 empty, irq drops
    '{1'b1, 8'h20, 32'hDEAD_BEEF, 32'h0},          // R7 word 0
    '{1'b1, 8'h3C, 32'h1234_5678, 32'h0},          // R7 word 7
    '{1'b0, 8'h20, 32'h0,         32'hDEAD_BEEF},  // R7
    '{1'b0, 8'h3C, 32'h0,         32'h1234_5678},  // R7
    '{1'b0, 8'h08, 32'h0,         32'h0},          // R6 set reads 0
    '{1'b0, 8'h0C, 32'h0,         32'h0},          // R6 clear reads 0
    '{1'b1, 8'h40, 32'hFFFF_FFFF, 32'h0},          // R8 unmapped write
    '{1'b0, 8'h40, 32'h0,         32'h0}           // R8 unmapped read
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = a; req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_write_i = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = a;
    #2 d = rsp_rdata_o;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #800000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 err", {31'b0, wr_err_o}, 32'h0);
    do_read(12'h000, d); check("R1 status", d, 32'h0);
    do_read(12'h004, d); check("R1 enable", d, 32'h0);
    for (int k = 0; k < 8; k++) begin
      do_read(12'(8'h20 + 4 * k), d); check("R1 mailbox", d, 32'h0);
    end

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        do_write({4'h0, VECS[i].off}, VECS[i].dat);
        check($sformatf("vec %0d irq", i), {31'b0, irq_o}, VECS[i].exp);
      end else begin
        do_read({4'h0, VECS[i].off}, d);
        check($sformatf("vec %0d rdata", i), d, VECS[i].exp);
      end
    end
    do_read(12'h03C, d); check("R8 mailbox untouched", d, 32'h1234_5678);
    do_read(12'h044, d); check("R8 unmapped 0x44", d, 32'h0);

    // R11 reads have no side effects: status read twice is unchanged
    do_read(12'h000, d); check("R11 status", d, 32'h0);

    // R2 aliasing above bit 7
    do_write(12'h124, 32'h0000_00AA);
    do_read(12'h024, d); check("R2 alias write", d, 32'h0000_00AA);
    do_read(12'h224, d); check("R2 alias read", d, 32'h0000_00AA);

    // R5 status read-only with error flag
    do_write(12'h000, 32'hFFFF_FFFF);
    check("R5 err pulse", {31'b0, wr_err_o}, 32'h1);
    do_read(12'h000, d); check("R5 status kept", d, 32'h0);
    check("R5 err clears", {31'b0, wr_err_o}, 32'h0);
    do_write(12'h004, 32'h0000_00F0);
    check("R5 no err on enable", {31'b0, wr_err_o}, 32'h0);

    // R9 remote set
    @(negedge clk_i);
    remote_set_valid_i = 1'b1; remote_set_data_i = 32'h20;
    @(negedge clk_i);
    remote_set_valid_i = 1'b0;
    check("R9 remote raises", {31'b0, irq_o}, 32'h1);
    // clear + remote set same bit: set wins
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 12'h00C; req_wdata_i = 32'h20;
    remote_set_valid_i = 1'b1; remote_set_data_i = 32'h20;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_write_i = 1'b0; remote_set_valid_i = 1'b0;
    check("R9 set after clear irq", {31'b0, irq_o}, 32'h1);
    do_read(12'h000, d); check("R9 set after clear status", d, 32'h20);
    // clear empties, remote sets a masked bit: irq drops
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 12'h00C; req_wdata_i = 32'h20;
    remote_set_valid_i = 1'b1; remote_set_data_i = 32'h01;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_write_i = 1'b0; remote_set_valid_i = 1'b0;
    check("R9 masked set after clear irq", {31'b0, irq_o}, 32'h0);
    do_read(12'h000, d); check("R9 masked status", d, 32'h01);

    // R4 / R10 enable zero keeps irq on empty status
    do_write(12'h004, 32'h1);
    do_write(12'h008, 32'h1);
    check("R3 raise", {31'b0, irq_o}, 32'h1);
    do_write(12'h004, 32'h0);
    check("R10 enable write keeps irq", {31'b0, irq_o}, 32'h1);
    do_write(12'h00C, 32'h1);
    check("R4 en zero keeps irq", {31'b0, irq_o}, 32'h1);
    do_read(12'h000, d); check("R4 status empty", d, 32'h0);
    do_write(12'h004, 32'h1);
    check("R10 enable write no drop", {31'b0, irq_o}, 32'h1);
    do_write(12'h00C, 32'h0);
    check("R4 empty with enable drops", {31'b0, irq_o}, 32'h0);
    do_write(12'h044, 32'hFFFF_FFFF);
    check("R8 unmapped write no irq", {31'b0, irq_o}, 32'h0);

    finish_run();
  end
endmodule